// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for each beat of a read or write burst on a four-bank, 32-bit synchronous DRAM whose rows hold 256 columns. A memory controller pulses a load strobe when it issues a Read or Write command, together with the starting column and the burst settings. From the next cycle the block presents one column per enabled clock, following the programmed length and wrap order, and flags the final beat.

A burst ends on its own after its fixed length. It can also be cut short by a Burst Stop strobe or by a fresh column command, which restarts the sequence at once. Full-page bursts run around the whole row without end until stopped. A registered copy of the clock enable freezes the sequence one cycle after it is sampled low, which is how clock suspend behaves. A single-write option makes writes one beat long while reads keep the programmed length.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is asserted and after it is released, `col_valid` and `col_last` are 0 and `col` is 0 until a command is accepted.
- R2: A command is accepted at a rising edge where the enable registered at the previous edge is 1 and `cmd_load` is 1. From that edge on, `col_valid` is 1 and `col` equals the `start_col` that was sampled.
- R3: `burst_len` encodes the length: 3'b000 is 1 beat, 3'b001 is 2, 3'b010 is 4, 3'b011 is 8 and 3'b111 is full page. With `burst_interleave` at 0, a burst of length L steps upward by one per enabled edge and wraps inside the L-aligned block that holds the start column.
- R4: With `burst_interleave` at 1, beat k of a fixed-length burst of length L has column `(start & ~(L-1)) | ((start ^ k) & (L-1))`.
- R5: Length code 3'b000 and the reserved codes 3'b100, 3'b101 and 3'b110 give a single-beat burst.
- R6: A full-page burst adds one per enabled edge modulo 256 and wraps from 255 to 0. It never ends on its own, and `col_last` stays 0 throughout.
- R7: `col_last` is 1 exactly on the final beat of a fixed-length burst. After the next enabled edge with no load, `col_valid` is 0.
- R8: An accepted `cmd_stop` without `cmd_load` clears `col_valid` at that edge.
- R9: A load during a burst restarts at the new start column with the new settings, and the older burst is dropped. If load and stop arrive together, the load wins.
- R10: With `read_burst_single_write` at 1, a load with `cmd_write` at 1 gives a single beat. A load with `cmd_write` at 0 keeps the programmed length.
- R11: If `cke` is 0 at edge n, then at edge n+1 the outputs hold their values and any strobes are ignored.
- R12: A full-page burst ignores `burst_interleave` and always counts sequentially.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable. It takes effect one edge after it is sampled |
| cmd_load | input | 1 | A Read or Write column command is issued |
| cmd_write | input | 1 | 1 for a Write command, 0 for a Read command |
| cmd_stop | input | 1 | Burst Stop command |
| start_col | input | 8 | Starting column of the burst |
| burst_len | input | 3 | Burst length code |
| burst_interleave | input | 1 | 1 selects interleaved order, 0 selects sequential order |
| read_burst_single_write | input | 1 | 1 makes writes single-beat |
| col | output | 8 | Current column address |
| col_valid | output | 1 | A burst beat is present |
| col_last | output | 1 | The current beat is the final beat of a fixed-length burst |

## Verification
Directed bursts use start columns that do not sit on an aligned boundary, such as 6 with length 4 and 5 with length 8 interleaved. These separate an aligned-block wrap from a plain increment, and an XOR order from an additive one. A full-page run that crosses column 255 shows the modulo-256 wrap and that no final beat is ever flagged. Truncation is tested three ways: a stop strobe, a reload partway through a burst, and a load with a stop in the same cycle, which shows the priority between them. Cycles with the clock enable low, and with strobes asserted during the frozen edge, show the one-cycle lag and that commands are ignored while suspended. Random mixes of length codes, including the reserved ones, together with the order, the single-write setting and the clock enable, are compared cycle by cycle against a reference model in the bench.

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             cmd_load,
  input  logic             cmd_write,
  input  logic             cmd_stop,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       burst_len,
  input  logic             burst_interleave,
  input  logic             read_burst_single_write,
  output logic [COL_W-1:0] col,
  output logic             col_valid,
  output logic             col_last
);
  localparam logic [COL_W-1:0] ALL_ONES = {COL_W{1'b1}};

  logic             ce_q, act, il, full;
  logic [COL_W-1:0] base, beat, mask, order;
  logic             one_beat, len_full;

  function automatic logic [COL_W-1:0] mask_of(input logic [2:0] code);
    case (code)
      3'b001:  return COL_W'(1);
      3'b010:  return COL_W'(3);
      3'b011:  return COL_W'(7);
      3'b111:  return ALL_ONES;
      default: return '0;
    endcase
  endfunction

  assign one_beat  = cmd_write && read_burst_single_write;
  assign len_full  = !one_beat && (burst_len == 3'b111);
  assign order     = il ? (base ^ beat) : (base + beat);
  assign col       = act ? ((base & ~mask) | (order & mask)) : '0;
  assign col_valid = act;
  assign col_last  = act && !full && (beat == mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_q <= 1'b1;
      act  <= 1'b0;
      il   <= 1'b0;
      full <= 1'b0;
      base <= '0;
      beat <= '0;
      mask <= '0;
    end else begin
      ce_q <= cke;
      if (ce_q) begin
        if (cmd_load) begin
          act  <= 1'b1;
          base <= start_col;
          beat <= '0;
          mask <= one_beat ? '0 : mask_of(burst_len);
          full <= len_full;
          il   <= burst_interleave && !len_full;
        end else if (cmd_stop) begin
          act <= 1'b0;
        end else if (act) begin
          if (col_last) act <= 1'b0;
          else          beat <= beat + 1'b1;
        end
      end
    end
  end

  a_r11_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_q |=> $stable(col) && $stable(col_valid) && $stable(col_last));

  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    ce_q && cmd_load |=> col_valid && col == $past(start_col));

  a_r8_stop: assert property (@(posedge clk) disable iff (!rst_n)
    ce_q && cmd_stop && !cmd_load |=> !col_valid);

  a_r7_end: assert property (@(posedge clk) disable iff (!rst_n)
    ce_q && col_last && !cmd_load |=> !col_valid);

  a_r6_full_run: assert property (@(posedge clk) disable iff (!rst_n)
    ce_q && col_valid && full && !cmd_stop && !cmd_load |=>
      col_valid && col == COL_W'($past(col) + 1'b1));

  a_r7_last_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid);
endmodule

// File: tb/sdram_burst_colgen_test.sv
module sdram_burst_colgen_test;
  logic clk = 0, rst_n = 0, cke = 1, cmd_load = 0, cmd_write = 0, cmd_stop = 0;
  logic [7:0] start_col = 0;
  logic [2:0] burst_len = 0;
  logic burst_interleave = 0, read_burst_single_write = 0;
  logic [7:0] col;
  logic col_valid, col_last;

  int total = 0, bad = 0;
  bit m_ce = 1, m_act = 0, m_il = 0, m_full = 0;
  logic [7:0] m_base = 0, m_beat = 0, m_mask = 0;

  always #4 clk = ~clk;

  sdram_burst_colgen uut (.clk, .rst_n, .cke, .cmd_load, .cmd_write, .cmd_stop,
    .start_col, .burst_len, .burst_interleave, .read_burst_single_write,
    .col, .col_valid, .col_last);

  function automatic logic [7:0] len_mask(input logic [2:0] c);
    case (c)
      3'b001: return 8'd1;
      3'b010: return 8'd3;
      3'b011: return 8'd7;
      3'b111: return 8'hFF;
      default: return 8'd0;
    endcase
  endfunction

  function automatic logic [7:0] exp_col();
    logic [7:0] k;
    if (!m_act) return 8'd0;
    k = m_il ? (m_base ^ m_beat) : 8'(m_base + m_beat);
    return (m_base & ~m_mask) | (k & m_mask);
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic k, ld, wr, sp, input logic [7:0] sc,
                      input logic [2:0] bl, input logic i, bw, input string tag);
    bit sw;
    cke = k; cmd_load = ld; cmd_write = wr; cmd_stop = sp; start_col = sc;
    burst_len = bl; burst_interleave = i; read_burst_single_write = bw;
    @(posedge clk);
    if (m_ce) begin
      if (ld) begin
        sw = wr && bw;
        m_act = 1; m_base = sc; m_beat = 0;
        m_mask = sw ? 8'd0 : len_mask(bl);
        m_full = !sw && bl == 3'b111;
        m_il = i && !m_full;
      end else if (sp) m_act = 0;
      else if (m_act) begin
        if (!m_full && m_beat == m_mask) m_act = 0;
        else m_beat++;
      end
    end
    m_ce = k;
    @(negedge clk);
    check(tag, "col", col, exp_col());
    check(tag, "valid", col_valid, m_act);
    check(tag, "last", col_last, m_act && !m_full && m_beat == m_mask);
  endtask

  task automatic idle(input int n, input string tag);
    for (int j = 0; j < n; j++) step(1, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(200000 * 8);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    string tag;
    void'($urandom(32'h5D3A));
    repeat (3) @(negedge clk);
    check("R1", "valid in reset", col_valid, 0);
    check("R1", "col in reset", col, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1", "last after reset", col_last, 0);
    check("R1", "valid after reset", col_valid, 0);

    step(1, 1, 0, 0, 8'd6, 3'b010, 0, 0, "R2");
    check("R2", "start col", col, 6);
    idle(3, "R3");
    idle(1, "R7");
    check("R7", "ended", col_valid, 0);

    step(1, 1, 0, 0, 8'd5, 3'b011, 1, 0, "R4");
    idle(7, "R4");
    check("R4", "final interleave col", col, 2);
    idle(1, "R7");

    step(1, 1, 0, 0, 8'd9, 3'b000, 0, 0, "R5");
    idle(1, "R5");
    step(1, 1, 0, 0, 8'd33, 3'b100, 0, 0, "R5");
    idle(1, "R5");
    step(1, 1, 0, 0, 8'd34, 3'b110, 1, 0, "R5");
    idle(1, "R5");

    step(1, 1, 0, 0, 8'd254, 3'b111, 0, 0, "R6");
    idle(2, "R6");
    check("R6", "wrapped col", col, 0);
    idle(300, "R6");
    step(1, 0, 0, 1, 0, 0, 0, 0, "R8");
    idle(2, "R8");

    step(1, 1, 0, 0, 8'd3, 3'b111, 1, 0, "R12");
    idle(5, "R12");
    check("R12", "seq col", col, 8);

    step(1, 1, 0, 0, 8'd16, 3'b011, 0, 0, "R9");
    idle(2, "R9");
    step(1, 1, 0, 0, 8'd41, 3'b001, 0, 0, "R9");
    idle(2, "R9");
    step(1, 1, 0, 0, 8'd70, 3'b011, 0, 0, "R9");
    step(1, 1, 0, 1, 8'd90, 3'b010, 0, 0, "R9");
    idle(4, "R9");

    step(1, 1, 1, 0, 8'd12, 3'b011, 0, 1, "R10");
    idle(2, "R10");
    step(1, 1, 0, 0, 8'd12, 3'b010, 0, 1, "R10");
    idle(4, "R10");

    step(1, 1, 0, 0, 8'd0, 3'b011, 0, 0, "R11");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R11");
    step(0, 1, 0, 0, 8'd77, 3'b000, 0, 0, "R11");
    step(1, 0, 0, 1, 0, 0, 0, 0, "R11");
    idle(8, "R11");

    for (int n = 0; n < 4000; n++) begin
      logic k, ld, wr, sp, i, bw;
      logic [2:0] bl;
      k  = ($urandom % 8) != 0;
      ld = ($urandom % 6) == 0;
      wr = $urandom % 2;
      sp = ($urandom % 12) == 0;
      i  = $urandom % 2;
      bw = ($urandom % 4) == 0;
      bl = 3'($urandom);
      tag = m_full ? "R6" : (m_il ? "R4" : "R3");
      step(k, ld, wr, sp, 8'($urandom), bl, i, bw, tag);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule